// File: doc/BRIEF.md
# Completion Queue Index Manager

This block hands out write addresses for completion records that are stored in host memory. Two requesters, one for receive and one for transmit, ask for a completion slot. The block keeps a producer index for each queue and a consumer index that software writes back. It grants at most one request per cycle and drives a write strobe with the host byte address of the slot. Forming the record contents and running the bus transfer happen outside this block.

Configuration chooses one of two layouts. In split mode the two directions own separate queues with separate base addresses. In shared mode both directions fill the receive queue through a single index sequence. A second setting makes each entry either one 32-bit word or two. The block counts the free entries from the producer and consumer indices. A low-space flag per queue tells software when to move its consumer index forward. When a queue is full, its requests are held back and are not lost.

Top module: `cplq_ptr_unit`

## Requirements
- R1: After reset, both producer and consumer indices are 0. Both queues therefore report 1023 free entries, the strobe is low while nothing is requested, and the first granted write goes to the aligned base address.
- R2: The write address is the base with bits 7:0 forced to zero, plus the producer index times 4 when cfgWide=0 or times 8 when cfgWide=1.
- R3: A producer index advances by one on each write to its queue and wraps from 1023 to 0, so the write after index 1023 lands on the aligned base again.
- R4: Free entries of a queue equal 1023 - ((producer - consumer) mod 1024). With 0 free entries, a request for that queue gets no grant and no strobe. The request stays pending and is served, at the index it would have had, once a consumer write frees space.
- R5: rxLow is 1 exactly when the receive queue has fewer free entries than cfgThresh. txLow does the same for the transmit queue. A threshold of 0 never raises a flag.
- R6: A pulse on rxConsWr loads rxConsIdx as the receive consumer index, and a pulse on txConsWr loads txConsIdx as the transmit consumer index. In shared mode (cfgShared=1) txConsWr has no effect.
- R7: In split mode (cfgShared=0) the receive and transmit queues have independent indices. Transmit writes use cfgTxBase.
- R8: In shared mode, writes in both directions use cfgRxBase and one common producer index, space is judged on the receive queue alone, and txLow stays 0.
- R9: At most one grant is given per cycle. A lone request with room is granted in the same cycle. When both directions can be served, the grant goes to the direction not granted last, and receive goes first after reset.
- R10: wrStrobe is 1 exactly in cycles with a grant. wrIsTx is 1 when that grant is for transmit. A grant is only given to an asserted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgShared | input | 1 | 1: both directions share the receive queue |
| cfgWide | input | 1 | 1: two-word (8-byte) entries, 0: one-word entries |
| cfgRxBase | input | 32 | Receive (or shared) queue base; bits 7:0 ignored |
| cfgTxBase | input | 32 | Transmit queue base; bits 7:0 ignored |
| cfgThresh | input | 10 | Free-entry threshold for the low flags |
| rxReq | input | 1 | Receive completion slot request |
| txReq | input | 1 | Transmit completion slot request |
| rxConsWr | input | 1 | Load receive consumer index |
| rxConsIdx | input | 10 | New receive consumer index |
| txConsWr | input | 1 | Load transmit consumer index |
| txConsIdx | input | 10 | New transmit consumer index |
| rxGnt | output | 1 | Receive request served this cycle |
| txGnt | output | 1 | Transmit request served this cycle |
| wrStrobe | output | 1 | Completion write valid |
| wrIsTx | output | 1 | Current write belongs to transmit |
| wrAddr | output | 32 | Host byte address of the completion slot |
| rxLow | output | 1 | Receive queue free space below threshold |
| txLow | output | 1 | Transmit queue free space below threshold |

## Verification
A corrupted producer index shows up in wrAddr on the very next strobe to that queue. The same fault also moves the low flag and the full point, which the free-count model compares in every cycle. A bad consumer load shows as a low flag that disagrees with the model in the cycle after the load, or as a grant given into a full queue, or held back from a queue that has room. A wrong arbitration bit appears as a grant order broken in the first cycle where both directions can be served.

// File: rtl/cplq_pkg.sv
package cplq_pkg;

  // Strobes from the control to the index datapath for one cycle.
  typedef struct packed {
    logic fire;    // a write is issued this cycle
    logic pickTx;  // granted direction is transmit
    logic adv0;    // advance producer of queue 0 (receive / shared)
    logic adv1;    // advance producer of queue 1 (transmit, split only)
  } cplq_stb_t;

endpackage

// File: rtl/cplq_ctrl.sv
module cplq_ctrl
  import cplq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgShared,
  input  logic      rxReq,
  input  logic      txReq,
  input  logic      full0,
  input  logic      full1,
  output cplq_stb_t stb,
  output logic      rxGnt,
  output logic      txGnt
);

  logic preferTx;
  logic rxOk;
  logic txOk;
  logic txFull;

  always_comb begin
    txFull = cfgShared ? full0 : full1;
    rxOk   = rxReq && !full0;
    txOk   = txReq && !txFull;

    stb.fire   = rxOk || txOk;
    stb.pickTx = (rxOk && txOk) ? preferTx : txOk;
    stb.adv0   = stb.fire && (cfgShared || !stb.pickTx);
    stb.adv1   = stb.fire && !cfgShared && stb.pickTx;

    rxGnt = stb.fire && !stb.pickTx;
    txGnt = stb.fire && stb.pickTx;
  end

  // Round-robin state: after any grant, prefer the other direction.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preferTx <= 1'b0;
    end else if (stb.fire) begin
      preferTx <= !stb.pickTx;
    end
  end

endmodule

// File: rtl/cplq_dpath.sv
module cplq_dpath
  import cplq_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 256,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned LOWB = $clog2(ALIGN),
  localparam int unsigned NQ   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  cplq_stb_t       stb,
  input  logic            cfgShared,
  input  logic            cfgWide,
  input  logic [AW-1:0]   base0,
  input  logic [AW-1:0]   base1,
  input  logic [IDXW-1:0] thresh,
  input  logic            cons0Wr,
  input  logic [IDXW-1:0] cons0Idx,
  input  logic            cons1Wr,
  input  logic [IDXW-1:0] cons1Idx,
  output logic [IDXW-1:0] free0,
  output logic [IDXW-1:0] free1,
  output logic            full0,
  output logic            full1,
  output logic            low0,
  output logic            low1,
  output logic [AW-1:0]   wrAddr
);

  localparam logic [IDXW-1:0] MAXFREE = IDXW'(DEPTH - 1);

  logic [NQ-1:0][IDXW-1:0] prodQ;
  logic [NQ-1:0][IDXW-1:0] consQ;
  logic [NQ-1:0][IDXW-1:0] freeQ;
  logic [NQ-1:0]           advQ;
  logic [NQ-1:0]           loadQ;
  logic [NQ-1:0][IDXW-1:0] loadVal;

  always_comb begin
    advQ    = {stb.adv1, stb.adv0};
    loadQ   = {cons1Wr && !cfgShared, cons0Wr};
    loadVal = {cons1Idx, cons0Idx};
  end

  // Index registers for every queue; power-of-two depth wraps naturally.
  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (!rstN) begin
        prodQ[q] <= '0;
        consQ[q] <= '0;
      end else begin
        if (advQ[q])  prodQ[q] <= prodQ[q] + 1'b1;
        if (loadQ[q]) consQ[q] <= loadVal[q];
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_free
    assign freeQ[g] = MAXFREE - (prodQ[g] - consQ[g]);
  end

  assign free0 = freeQ[0];
  assign free1 = freeQ[1];
  assign full0 = (freeQ[0] == '0);
  assign full1 = (freeQ[1] == '0);
  assign low0  = (freeQ[0] < thresh);
  assign low1  = !cfgShared && (freeQ[1] < thresh);

  // Address: aligned base of the selected queue plus scaled producer index.
  logic            selQ;
  logic [AW-1:0]   baseSel;
  logic [AW-1:0]   baseAl;
  logic [AW-1:0]   offs;

  always_comb begin
    selQ    = !cfgShared && stb.pickTx;
    baseSel = selQ ? base1 : base0;
    baseAl  = {baseSel[AW-1:LOWB], {LOWB{1'b0}}};
    offs    = AW'(prodQ[selQ]) << (cfgWide ? 3 : 2);
    wrAddr  = baseAl + offs;
  end

endmodule

// File: rtl/cplq_ptr_unit.sv
module cplq_ptr_unit
  import cplq_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 32,
  localparam int unsigned IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgShared,
  input  logic            cfgWide,
  input  logic [AW-1:0]   cfgRxBase,
  input  logic [AW-1:0]   cfgTxBase,
  input  logic [IDXW-1:0] cfgThresh,
  input  logic            rxReq,
  input  logic            txReq,
  input  logic            rxConsWr,
  input  logic [IDXW-1:0] rxConsIdx,
  input  logic            txConsWr,
  input  logic [IDXW-1:0] txConsIdx,
  output logic            rxGnt,
  output logic            txGnt,
  output logic            wrStrobe,
  output logic            wrIsTx,
  output logic [AW-1:0]   wrAddr,
  output logic            rxLow,
  output logic            txLow
);

  cplq_stb_t       stb;
  logic            qFull0;
  logic            qFull1;
  logic [IDXW-1:0] qFree0;
  logic [IDXW-1:0] qFree1;

  cplq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgShared(cfgShared),
    .rxReq    (rxReq),
    .txReq    (txReq),
    .full0    (qFull0),
    .full1    (qFull1),
    .stb      (stb),
    .rxGnt    (rxGnt),
    .txGnt    (txGnt)
  );

  cplq_dpath #(.DEPTH(DEPTH), .AW(AW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgShared(cfgShared),
    .cfgWide  (cfgWide),
    .base0    (cfgRxBase),
    .base1    (cfgTxBase),
    .thresh   (cfgThresh),
    .cons0Wr  (rxConsWr),
    .cons0Idx (rxConsIdx),
    .cons1Wr  (txConsWr),
    .cons1Idx (txConsIdx),
    .free0    (qFree0),
    .free1    (qFree1),
    .full0    (qFull0),
    .full1    (qFull1),
    .low0     (rxLow),
    .low1     (txLow),
    .wrAddr   (wrAddr)
  );

  assign wrStrobe = stb.fire;
  assign wrIsTx   = stb.fire && stb.pickTx;

endmodule

// File: rtl/cplq_checker.sv
module cplq_checker #(
  parameter int unsigned IDXW = 10,
  parameter int unsigned AW   = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgShared,
  input logic            cfgWide,
  input logic            rxReq,
  input logic            txReq,
  input logic            rxConsWr,
  input logic            rxGnt,
  input logic            txGnt,
  input logic            wrStrobe,
  input logic [AW-1:0]   wrAddr,
  input logic            txLow,
  input logic [IDXW-1:0] qFree0
);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !(rxGnt && txGnt)); // R9

  AST_RX_GNT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rxGnt |-> rxReq); // R10

  AST_TX_GNT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    txGnt |-> txReq); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!rxReq && !txReq) |-> !wrStrobe); // R10

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (qFree0 == '0) |-> !rxGnt); // R4

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rxGnt && !rxConsWr) |=> (qFree0 == $past(qFree0) - 1'b1)); // R4

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && cfgWide) |-> (wrAddr[2:0] == 3'b000)); // R2

  AST_SHARED_NO_TXLOW: assert property (@(posedge clk) disable iff (!rstN)
    cfgShared |-> !txLow); // R8

endmodule

bind cplq_ptr_unit cplq_checker #(.IDXW(IDXW), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgShared(cfgShared),
  .cfgWide  (cfgWide),
  .rxReq    (rxReq),
  .txReq    (txReq),
  .rxConsWr (rxConsWr),
  .rxGnt    (rxGnt),
  .txGnt    (txGnt),
  .wrStrobe (wrStrobe),
  .wrAddr   (wrAddr),
  .txLow    (txLow),
  .qFree0   (qFree0)
);

// File: tb/sim_cplq_ptr_unit.sv
`timescale 1ns/1ps
module sim_cplq_ptr_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgShared, cfgWide;
  logic [31:0] cfgRxBase, cfgTxBase;
  logic [9:0]  cfgThresh;
  logic        rxReq, txReq, rxConsWr, txConsWr;
  logic [9:0]  rxConsIdx, txConsIdx;
  logic        rxGnt, txGnt, wrStrobe, wrIsTx, rxLow, txLow;
  logic [31:0] wrAddr;

  always #5 clk = ~clk;

  cplq_ptr_unit u0 (
    .clk(clk), .rstN(rstN), .cfgShared(cfgShared), .cfgWide(cfgWide),
    .cfgRxBase(cfgRxBase), .cfgTxBase(cfgTxBase), .cfgThresh(cfgThresh),
    .rxReq(rxReq), .txReq(txReq), .rxConsWr(rxConsWr), .rxConsIdx(rxConsIdx),
    .txConsWr(txConsWr), .txConsIdx(txConsIdx), .rxGnt(rxGnt), .txGnt(txGnt),
    .wrStrobe(wrStrobe), .wrIsTx(wrIsTx), .wrAddr(wrAddr), .rxLow(rxLow),
    .txLow(txLow)
  );

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  // Reference model state
  int  mp [2];
  int  mc [2];
  bit  mPreferTx;
  bit  lastGntTx;
  logic [31:0] lastAddr;
  bit  lastFire;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int freeOf(input int q);
    return 1023 - ((mp[q] - mc[q]) & 1023);
  endfunction

  function automatic logic [31:0] addrOf(input logic [31:0] base, input int idx, input bit wide);
    return {base[31:8], 8'h00} + 32'(idx * (wide ? 8 : 4));
  endfunction

  task automatic modelReset();
    mp[0] = 0; mp[1] = 0; mc[0] = 0; mc[1] = 0; mPreferTx = 0;
  endtask

  task automatic doReset(input bit shared, input bit wide, input logic [9:0] th);
    rstN = 0; rxReq = 0; txReq = 0; rxConsWr = 0; txConsWr = 0;
    rxConsIdx = 0; txConsIdx = 0;
    cfgShared = shared; cfgWide = wide; cfgThresh = th;
    repeat (2) @(negedge clk);
    modelReset();
    rstN = 1;
  endtask

  // Compare all outputs for one cycle, then advance the model at the edge.
  task automatic step();
    int  qT, q;
    bit  rxOk, txOk, fire, pickTx;
    logic [31:0] eAddr;
    #1;
    qT   = cfgShared ? 0 : 1;
    rxOk = rxReq && (freeOf(0) > 0);
    txOk = txReq && (freeOf(qT) > 0);
    fire = rxOk || txOk;
    pickTx = (rxOk && txOk) ? mPreferTx : txOk;
    check(rxGnt == (fire && !pickTx), "R9 R4 rxGnt", rxGnt, fire && !pickTx);
    check(txGnt == (fire && pickTx), "R9 R4 txGnt", txGnt, fire && pickTx);
    check(wrStrobe == fire, "R10 wrStrobe", wrStrobe, fire);
    check(wrIsTx == (fire && pickTx), "R10 wrIsTx", wrIsTx, fire && pickTx);
    q = pickTx ? qT : 0;
    eAddr = addrOf((cfgShared || !pickTx) ? cfgRxBase : cfgTxBase, mp[q], cfgWide);
    if (fire) check(wrAddr == eAddr, "R2 R7 R8 wrAddr", wrAddr, eAddr);
    check(rxLow == (freeOf(0) < int'(cfgThresh)), "R5 rxLow", rxLow, freeOf(0) < int'(cfgThresh));
    check(txLow == (!cfgShared && freeOf(1) < int'(cfgThresh)), "R5 R8 txLow",
          txLow, !cfgShared && freeOf(1) < int'(cfgThresh));
    lastFire = wrStrobe; lastGntTx = txGnt; lastAddr = wrAddr;
    @(posedge clk);
    if (fire) begin
      mp[q] = (mp[q] + 1) & 1023;
      mPreferTx = !pickTx;
    end
    if (rxConsWr) mc[0] = rxConsIdx;
    if (txConsWr && !cfgShared) mc[1] = txConsIdx;
    @(negedge clk);
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      rxReq = ($urandom % 4) != 0;
      txReq = ($urandom % 3) == 0;
      rxConsWr = ($urandom % 16) == 0;
      txConsWr = ($urandom % 16) == 0;
      rxConsIdx = 10'((mp[0] - ($urandom % 40)) & 1023);
      txConsIdx = 10'((mp[1] - ($urandom % 40)) & 1023);
      step();
    end
    rxReq = 0; txReq = 0; rxConsWr = 0; txConsWr = 0;
  endtask

  initial begin
    bit ok;
    bit prevTx;
    logic r0;
    void'($urandom(32'h5eed_c0de));
    cfgRxBase = 32'h8000_13A5;
    cfgTxBase = 32'h4000_22FF;
    @(negedge clk);

    // R1: reset state
    doReset(0, 0, 10'd16);
    #1;
    check(wrStrobe == 0, "R1 idle strobe", wrStrobe, 0);
    check(rxLow == 0 && txLow == 0, "R1 low flags", {rxLow, txLow}, 0);
    @(negedge clk);
    rxReq = 1; #1;
    check(wrAddr == 32'h8000_1300, "R1 first addr", wrAddr, 32'h8000_1300);
    step();
    txReq = 1; rxReq = 0; #1;
    check(wrAddr == 32'h4000_2200 && wrIsTx, "R7 tx base", wrAddr, 32'h4000_2200);
    step();
    txReq = 0;

    // Split, one-word entries, random traffic
    randomRun(700);

    // R4 / R3: fill receive queue, stall, release, wrap
    doReset(0, 0, 10'd100);
    rxReq = 1;
    for (int i = 0; i < 1023; i++) step();
    for (int i = 0; i < 4; i++) begin
      #1;
      check(!rxGnt && !wrStrobe, "R4 stall when full", {rxGnt, wrStrobe}, 0);
      check(rxLow == 1, "R5 low when full", rxLow, 1);
      step();
    end
    rxConsWr = 1; rxConsIdx = 10'd512;
    step();
    rxConsWr = 0;
    #1;
    check(rxGnt && wrAddr == 32'h8000_1300 + 32'd4092, "R4 pending served", wrAddr,
          32'h8000_1300 + 32'd4092);
    step();
    #1;
    check(rxGnt && wrAddr == 32'h8000_1300, "R3 wrap to base", wrAddr, 32'h8000_1300);
    step();
    rxReq = 0;

    // R9: alternation, split, two-word entries
    doReset(0, 1, 10'd0);
    rxReq = 1; txReq = 1;
    ok = 1; prevTx = 1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!lastFire || lastGntTx == prevTx) ok = 0;
      prevTx = lastGntTx;
    end
    check(ok, "R9 alternation starting with rx", ok, 1);
    rxReq = 0; txReq = 0;
    randomRun(500);

    // R8 / R6: shared queue, two-word entries
    doReset(1, 1, 10'd30);
    rxReq = 1; step(); rxReq = 0; txReq = 1; #1;
    check(wrAddr == 32'h8000_1308 && wrIsTx, "R8 shared tx addr", wrAddr, 32'h8000_1308);
    step(); txReq = 0;
    rxReq = 1;
    for (int i = 0; i < 1000; i++) step();
    rxReq = 0; #1;
    r0 = rxLow;
    txConsWr = 1; txConsIdx = 10'd1000;
    step();
    txConsWr = 0; #1;
    check(rxLow == r0 && r0 == 1 && txLow == 0, "R6 tx consumer ignored in shared",
          {rxLow, txLow}, {r0, 1'b0});
    rxConsWr = 1; rxConsIdx = 10'd1000;
    step();
    rxConsWr = 0; #1;
    check(rxLow == 0, "R6 rx consumer frees space", rxLow, 0);
    randomRun(800);

    // Shared, one-word entries
    doReset(1, 0, 10'd5);
    randomRun(500);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule